// File: doc/BRIEF.md
# Fixed-Latency Interrupt Entry Sequencer

This block decides when a pending interrupt is taken by a core whose instruction cycle is four clocks long. Each instruction needs either one or two of those cycles. The block produces the strobes that enter the handler: it pushes the return address, clears the global interrupt enable and loads the program counter with the vector. The delay from recognising a request to the vector load is the same whether the interrupted instruction was single-cycle or two-cycle. When the interrupted instruction finishes in one cycle, the block fills the gap with an inserted dead cycle. Only the return address is saved. The handler saves the working register and status itself.

Internal requests are already aligned to the instruction cycle and are sampled directly. External requests pass through a clock synchroniser and then a register that loads only on the last quarter of a cycle. This fixes an external request to one cycle boundary and removes the one-cycle jitter it would otherwise have. A return-from-interrupt input pops the call stack and sets the enable again.

The quarter count `phase` runs 0, 1, 2, 3, where 0 is the first quarter (Q1) and 3 is the last (Q4). The state machine has four states:
- `ST_IDLE`: no entry in progress.
- `ST_DRAIN`: the second half of a two-cycle instruction, or the dead cycle.
- `ST_PUSH`: the return address is pushed and the enable is cleared.
- `ST_VECT`: the vector is loaded.

Every transition happens at the clock edge that ends a Q4:
- `ST_IDLE`→`ST_DRAIN` when a recognised request is pending.
- `ST_DRAIN`→`ST_PUSH` always.
- `ST_PUSH`→`ST_VECT` always.
- `ST_VECT`→`ST_IDLE` always.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held and straight after it, every strobe output and `dead_cyc` are low.
- R2: The strobes `vec_load`, `ret_push`, `gie_clr`, `stk_pop` and `gie_set` are each one clock wide and occur only while `phase` is 3 (Q4).
- R3: An internal request that is high at Q1 (`phase` 0) of cycle N, with `gie` high and no entry in progress, gives exactly one `vec_load` pulse, at Q4 of cycle N+3.
- R4: `dead_cyc` is high for all four quarters of cycle N+1 when `two_cyc` was low at Q1 of cycle N, and stays low when `two_cyc` was high.
- R5: `ret_push` and `gie_clr` pulse together at Q4 of cycle N+2, while `gie` is still high.
- R6: `vec_addr` always reads the fixed vector address 0x004.
- R7: An external request held high for the whole of cycle N-1 is recognised at Q1 of cycle N. From there the timing of R3 to R5 follows, so the delay is fixed at one cycle more than for an internal request.
- R8: When `reti` is high during an instruction cycle with no entry in progress, `stk_pop` and `gie_set` pulse together at Q4 of that cycle.
- R9: Requests are ignored while `gie` is low, and while an entry is already in progress (cycles N to N+3). No extra `vec_load` pulse follows them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, four per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 2 | Quarter count, 0 = Q1 through 3 = Q4 |
| ext_irq | input | 1 | External request, asynchronous to the cycle |
| int_irq | input | 1 | Internal request, already cycle aligned |
| gie | input | 1 | Global interrupt enable state |
| two_cyc | input | 1 | Current instruction occupies two cycles |
| reti | input | 1 | Return-from-interrupt is executing |
| vec_load | output | 1 | Load program counter with vector |
| vec_addr | output | 13 | Vector address (0x004) |
| ret_push | output | 1 | Push return address onto the call stack |
| gie_clr | output | 1 | Clear the global enable |
| dead_cyc | output | 1 | Current cycle is an inserted dead cycle |
| stk_pop | output | 1 | Pop the call stack |
| gie_set | output | 1 | Set the global enable |

## Verification
The hardest case to reach is a request that stays high while an entry is already under way. The enable is still set during cycles N to N+2, so only the busy interlock stops a second entry. The directed opening holds the internal request high for several cycles across a whole entry, with the enable forced on. It also holds requests while the enable is low, and then drives an external request. A seeded random run follows. It mixes internal and external requests, the two-cycle flag and return-from-interrupt, and a cycle-level model in the bench predicts every strobe.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int QUARTERS = 4;
    localparam int PH_W     = $clog2(QUARTERS);
    localparam logic [PH_W-1:0] PH_FIRST = '0;
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(QUARTERS - 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_PUSH  = 2'd2,
        ST_VECT  = 2'd3
    } entry_state_e;
endpackage

// File: rtl/irq_ext_align.sv
module irq_ext_align
    import irq_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  logic            ext_raw,
    output logic            ext_aligned
);
    logic [SYNC_STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= ext_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    // load only at the edge ending Q4, so a request is fixed to one cycle boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ext_aligned <= 1'b0;
        else if (phase == PH_LAST) ext_aligned <= chain[SYNC_STAGES-1];
    end

    // R7: the aligned request changes only on a cycle boundary
    a_r7_align_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext_aligned) |-> $past(phase) == PH_LAST);
endmodule

// File: rtl/irq_recog.sv
module irq_recog
    import irq_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  logic            req_ext,
    input  logic            req_int,
    input  logic            gie,
    input  logic            two_cyc,
    input  logic            fsm_idle,
    input  logic            take,
    output logic            pending,
    output logic            dead_req
);
    logic accept;

    always_comb begin
        accept = (phase == PH_FIRST) && fsm_idle && !pending && gie && (req_ext || req_int);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            dead_req <= 1'b0;
        end else if (accept) begin
            pending  <= 1'b1;
            dead_req <= !two_cyc;
        end else if (take) begin
            pending  <= 1'b0;
        end
    end

    // R9: a pending request is never accepted again before the machine takes it
    a_r9_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !take) |=> pending);
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  logic            pending,
    input  logic            dead_req,
    input  logic            reti,
    output logic            fsm_idle,
    output logic            take,
    output logic            vec_load,
    output logic            ret_push,
    output logic            gie_clr,
    output logic            dead_cyc,
    output logic            stk_pop,
    output logic            gie_set
);
    entry_state_e state, state_nx;
    logic         q4;

    always_comb q4 = (phase == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (q4) begin
            unique case (state)
                ST_IDLE:  if (pending) state_nx = ST_DRAIN;
                ST_DRAIN: state_nx = ST_PUSH;
                ST_PUSH:  state_nx = ST_VECT;
                ST_VECT:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        fsm_idle = 1'b0;
        take     = 1'b0;
        vec_load = 1'b0;
        ret_push = 1'b0;
        gie_clr  = 1'b0;
        dead_cyc = 1'b0;
        stk_pop  = 1'b0;
        gie_set  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                fsm_idle = 1'b1;
                take     = pending && q4;
                stk_pop  = reti && q4;
                gie_set  = reti && q4;
            end
            ST_DRAIN: dead_cyc = dead_req;
            ST_PUSH: begin
                ret_push = q4;
                gie_clr  = q4;
            end
            ST_VECT: vec_load = q4;
        endcase
    end

    // R2: strobes only in the last quarter
    a_r2_strobe_on_q4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_load || ret_push || stk_pop || gie_set || gie_clr) |-> phase == PH_LAST);
    // R4: an inserted dead cycle covers the whole instruction cycle
    a_r4_dead_whole_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_cyc && phase != PH_LAST) |=> dead_cyc);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int              PC_W        = 13,
    parameter logic [PC_W-1:0] VEC_ADDR    = PC_W'(4),
    parameter int              SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  logic            ext_irq,
    input  logic            int_irq,
    input  logic            gie,
    input  logic            two_cyc,
    input  logic            reti,
    output logic            vec_load,
    output logic [PC_W-1:0] vec_addr,
    output logic            ret_push,
    output logic            gie_clr,
    output logic            dead_cyc,
    output logic            stk_pop,
    output logic            gie_set
);
    logic ext_al, pending, dead_req, fsm_idle, take;

    irq_ext_align #(.SYNC_STAGES(SYNC_STAGES)) u_align (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .ext_raw(ext_irq), .ext_aligned(ext_al)
    );

    irq_recog u_recog (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .req_ext(ext_al), .req_int(int_irq), .gie(gie), .two_cyc(two_cyc),
        .fsm_idle(fsm_idle), .take(take),
        .pending(pending), .dead_req(dead_req)
    );

    irq_entry_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .pending(pending), .dead_req(dead_req), .reti(reti),
        .fsm_idle(fsm_idle), .take(take),
        .vec_load(vec_load), .ret_push(ret_push), .gie_clr(gie_clr),
        .dead_cyc(dead_cyc), .stk_pop(stk_pop), .gie_set(gie_set)
    );

    always_comb vec_addr = VEC_ADDR;

    // R3: the vector load follows the push by exactly one instruction cycle
    a_r3_push_to_vector: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> $past(ret_push, 4));
    // R5: the push happens while the enable is still set
    a_r5_push_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        ret_push |-> gie);
    // R6: the vector address presented with the load is the fixed one
    a_r6_vector_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> vec_addr == VEC_ADDR);
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  phase = 2'd0;
    logic        ext_irq = 1'b0, int_irq = 1'b0, gie = 1'b0, two_cyc = 1'b0, reti = 1'b0;
    logic        vec_load, ret_push, gie_clr, dead_cyc, stk_pop, gie_set;
    logic [12:0] vec_addr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .ext_irq(ext_irq), .int_irq(int_irq), .gie(gie), .two_cyc(two_cyc), .reti(reti),
        .vec_load(vec_load), .vec_addr(vec_addr), .ret_push(ret_push), .gie_clr(gie_clr),
        .dead_cyc(dead_cyc), .stk_pop(stk_pop), .gie_set(gie_set)
    );

    always #10 clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string nm, input string req, input int cy);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s cycle %0d: actual %b expected %b", req, nm, cy, act, exp);
        end
    endtask

    function automatic logic exp_strobe(input bit busy, input int cyc, input int e, input int off, input int q);
        return busy && (cyc == e + off) && (q == 3);
    endfunction

    // reference state
    bit busy = 0;
    int ent = 0;
    bit rdead = 0;
    bit gie_m = 0;
    bit ext_prev = 0;

    initial begin
        void'($urandom(32'd1234));
        repeat (5) begin
            @(negedge clk);
            #5;
            vectors++;
            // R1: outputs quiet in reset
            chk(vec_load | ret_push | gie_clr | stk_pop | gie_set | dead_cyc, 1'b0, "reset outputs", "R1", -1);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            for (int q = 0; q < 4; q++) begin
                @(negedge clk);
                phase = 2'(q);
                if (q == 0) begin
                    ext_prev = ext_irq;
                    if (busy && cyc >= ent + 4) busy = 0;
                    int_irq = 0; ext_irq = 0; reti = 0; two_cyc = $urandom_range(0, 1) != 0;
                    if (cyc < 8) begin
                        gie_m = 0; int_irq = 1;                 // R9: enable low
                    end else if (cyc < 13) begin
                        if (cyc == 8) gie_m = 1;
                        int_irq = 1; two_cyc = (cyc == 8);      // R9: held during entry
                    end else if (cyc == 14 || cyc == 22 || cyc == 32) begin
                        reti = 1;                               // R8
                    end else if (cyc == 16) begin
                        int_irq = 1; two_cyc = 0;               // R4: dead cycle
                    end else if (cyc == 24) begin
                        ext_irq = 1;                            // R7
                    end else if (cyc >= 40) begin
                        int_irq = ($urandom_range(0, 5) == 0);
                        ext_irq = ($urandom_range(0, 5) == 0);
                        if (!busy && !gie_m) reti = ($urandom_range(0, 2) == 0);
                    end
                    gie = gie_m;
                    if (!busy && gie_m && (int_irq || ext_prev)) begin
                        busy = 1; ent = cyc; rdead = !two_cyc;
                    end
                end
                #5;
                vectors++;
                chk(vec_load, exp_strobe(busy, cyc, ent, 3, q), "vec_load", "R3", cyc);
                chk(ret_push, exp_strobe(busy, cyc, ent, 2, q), "ret_push", "R5", cyc);
                chk(gie_clr,  exp_strobe(busy, cyc, ent, 2, q), "gie_clr", "R5", cyc);
                chk(dead_cyc, busy && cyc == ent + 1 && rdead, "dead_cyc", "R4", cyc);
                chk(stk_pop,  reti && q == 3, "stk_pop", "R8", cyc);
                chk(gie_set,  reti && q == 3, "gie_set", "R8", cyc);
                if (vec_addr !== 13'h004) begin
                    miscompares++;
                    $display("FAIL R6 vec_addr: actual %h expected 004", vec_addr);
                end
                if (q == 3) begin
                    if (exp_strobe(busy, cyc, ent, 2, q)) gie_m = 0;
                    if (reti) gie_m = 1;
                end
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule